// File: doc/BRIEF.md
# Delta Modulation Spike Encoder

The encoder turns a stream of unsigned samples into spike events, one decision per clock cycle. On each rising edge it compares the incoming sample with the sample held in a previous-value register. It registers a positive spike when the sample has risen by strictly more than a threshold. When the negative channel is enabled, it registers a negative spike when the sample has fallen by strictly more than that same threshold. After the comparison, the register takes the new sample, so the next cycle measures the next step.

The positive spike is active-high on bit 0 of the spike output. The negative spike is active-low on bit 1, so the idle code is `2'b10`. The previous-value register is always visible on an output. For debugging, the register can be loaded with an arbitrary value in place of the sample. Because every cycle is an independent decision, a large sustained ramp produces a spike on every cycle.

Top module: `dm_spike_encoder`

## Requirements
- R1: While rst_ni is low, prev_o reads 0 and spike_o reads 2'b10 (no spike on either channel).
- R2: With load_prev_i low, prev_o shows data_i as sampled at the most recent rising edge.
- R3: With load_prev_i high, the register takes force_val_i at the edge, and data_i has no effect on prev_o.
- R4: spike_o[0] is 1 after an edge exactly when data_i minus the old register value, taken as a signed difference, is strictly greater than thresh_i. Unsigned wraparound never causes a spike.
- R5: spike_o[1] is 0 after an edge exactly when neg_en_i is high and the old register value minus data_i is strictly greater than thresh_i.
- R6: When neg_en_i was low at an edge, spike_o[1] is 1 after that edge, whatever the data.
- R7: The comparison always uses the register value held before the edge, including on a cycle in which the register is loaded from force_val_i.
- R8: Each cycle decides its spike independently. A ramp with steps larger than the threshold gives a spike on every consecutive cycle.
- R9: A positive and a negative spike never occur together: spike_o never reads 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 4 | Current sample, unsigned |
| thresh_i | input | 4 | Spike threshold, unsigned |
| neg_en_i | input | 1 | Enables the negative spike channel |
| load_prev_i | input | 1 | Loads force_val_i into the previous-value register |
| force_val_i | input | 4 | Value to load into the register |
| spike_o | output | 2 | Bit 0: positive spike, active high. Bit 1: negative spike, active low |
| prev_o | output | 4 | Current contents of the previous-value register |

## Verification
On every cycle, the assertions check four things. The register update follows load or data. A disabled negative channel stays high. A spike only follows a step in its own direction. The two spikes are never active together. Only the bench's scenarios can show that the strict threshold boundary and the wraparound-free subtraction give exactly the right decision for every value. They also show the reset code, the comparison against the old value on a forced-load cycle, and spikes on consecutive cycles along a steep ramp. The bench sweeps every threshold, every previous value and every sample with the negative channel both on and off, and it predicts each output arithmetically.

// File: rtl/dm_pkg.sv
package dm_pkg;
  parameter int unsigned DM_W = 4;
  localparam int unsigned POS_BIT = 0;
  localparam int unsigned NEG_BIT = 1;
  typedef logic [1:0] spike_t;
  // bit1 active-low, bit0 active-high
  localparam spike_t SPIKE_IDLE = 2'b10;
endpackage

// File: rtl/dm_prev_reg.sv
module dm_prev_reg #(
  parameter int unsigned W = dm_pkg::DM_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         load_i,
  input  logic [W-1:0] force_i,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] prev_q, prev_d;

  assign prev_d = load_i ? force_i : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/dm_delta_cmp.sv
module dm_delta_cmp #(
  parameter int unsigned W      = dm_pkg::DM_W,
  parameter bit          EN_NEG = 1'b1
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] thresh_i,
  input  logic         neg_en_i,
  output logic         pos_o,
  output logic         neg_o
);
  localparam int unsigned DW = W + 1;

  logic [DW-1:0] rise, fall;

  // extra bit acts as borrow: set means the step went the other way
  assign rise = {1'b0, cur_i}  - {1'b0, prev_i};
  assign fall = {1'b0, prev_i} - {1'b0, cur_i};

  assign pos_o = !rise[W] && (rise[W-1:0] > thresh_i);

  generate
    if (EN_NEG) begin : g_neg
      assign neg_o = neg_en_i && !fall[W] && (fall[W-1:0] > thresh_i);
    end else begin : g_no_neg
      logic unused_neg;
      assign unused_neg = ^{fall, neg_en_i};
      assign neg_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dm_spike_reg.sv
module dm_spike_reg (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pos_i,
  input  logic           neg_i,
  output dm_pkg::spike_t spike_o
);
  import dm_pkg::*;
  spike_t spike_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) spike_q <= SPIKE_IDLE;
    else begin
      spike_q[POS_BIT] <= pos_i;
      spike_q[NEG_BIT] <= ~neg_i;
    end
  end

  assign spike_o = spike_q;
endmodule

// File: rtl/dm_spike_encoder.sv
module dm_spike_encoder #(
  parameter int unsigned W      = dm_pkg::DM_W,
  parameter bit          EN_NEG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] thresh_i,
  input  logic         neg_en_i,
  input  logic         load_prev_i,
  input  logic [W-1:0] force_val_i,
  output logic [1:0]   spike_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] prev_val;
  logic         pos_hit, neg_hit;

  dm_prev_reg #(.W(W)) u_prev (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .load_i (load_prev_i),
    .force_i(force_val_i),
    .prev_o (prev_val)
  );

  dm_delta_cmp #(.W(W), .EN_NEG(EN_NEG)) u_cmp (
    .cur_i   (data_i),
    .prev_i  (prev_val),
    .thresh_i(thresh_i),
    .neg_en_i(neg_en_i),
    .pos_o   (pos_hit),
    .neg_o   (neg_hit)
  );

  dm_spike_reg u_spk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pos_i  (pos_hit),
    .neg_i  (neg_hit),
    .spike_o(spike_o)
  );

  assign prev_o = prev_val;

  logic past_valid;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid <= 1'b0;
    else         past_valid <= 1'b1;
  end

  // R2 R3
  prev_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid |-> prev_o == ($past(load_prev_i) ? $past(force_val_i) : $past(data_i)));

  // R6
  neg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid && !$past(neg_en_i)) |-> spike_o[1]);

  // R4
  pos_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid && spike_o[0]) |-> $past(data_i) > $past(prev_o));

  // R5
  neg_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid && !spike_o[1]) |-> $past(prev_o) > $past(data_i));

  // R9
  spike_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spike_o != 2'b01);
endmodule

// File: tb/dm_spike_encoder_bench.sv
module dm_spike_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] data = '0, thresh = '0, force_v = '0;
  logic neg_en = 1'b0, load = 1'b0;
  logic [1:0] spike;
  logic [W-1:0] prev;

  int checks = 0, errors = 0;
  int model_prev = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_spike_encoder u_dm_spike_encoder (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .thresh_i(thresh),
    .neg_en_i(neg_en), .load_prev_i(load), .force_val_i(force_v),
    .spike_o(spike), .prev_o(prev)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 time unit after the rising edge
  task automatic step(int d, int t, bit ne, bit ld, int fv, string tag);
    int exp_pos, exp_neg_n, exp_prev;
    @(negedge clk);
    data = d[W-1:0]; thresh = t[W-1:0]; neg_en = ne; load = ld; force_v = fv[W-1:0];
    exp_pos   = ((d - model_prev) > t) ? 1 : 0;
    exp_neg_n = (ne && ((model_prev - d) > t)) ? 0 : 1;
    exp_prev  = ld ? fv : d;
    @(posedge clk); #1;
    check({tag, " R4 pos"}, int'(spike[0]), exp_pos);
    check({tag, " R5 neg"}, int'(spike[1]), exp_neg_n);
    check({tag, ld ? " R3 prev" : " R2 prev"}, int'(prev), exp_prev);
    check({tag, " R9 excl"}, (spike == 2'b01) ? 1 : 0, 0);
    model_prev = exp_prev;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset prev", int'(prev), 0);
    check("R1 reset spike", int'(spike), 2);
    @(negedge clk); rst_n = 1'b1;

    // R7: load cycle compares against old register value
    step(15, 2, 1'b1, 1'b0, 0, "R7a");
    step(0, 2, 1'b1, 1'b1, 9, "R7 load");
    check("R7 neg on load", int'(spike[1]), 0);
    step(15, 3, 1'b1, 1'b1, 4, "R7 load2");
    check("R7 pos on load", int'(spike[0]), 1);

    // exhaustive sweep
    for (int t = 0; t < 16; t++)
      for (int ne = 0; ne < 2; ne++)
        for (int p = 0; p < 16; p++)
          for (int d = 0; d < 16; d++) begin
            step(d, 0, 1'b0, 1'b1, p, "sweep-load");
            step(d, t, ne[0], 1'b0, 0, ne ? "sweep R5" : "sweep R6");
          end

    // R8: steep ramp spikes every cycle
    step(0, 2, 1'b1, 1'b1, 0, "R8 init");
    for (int k = 1; k <= 5; k++) begin
      step(k * 3, 2, 1'b1, 1'b0, 0, "R8 up");
      check("R8 consecutive pos", int'(spike[0]), 1);
    end
    for (int k = 4; k >= 0; k--) begin
      step(k * 3, 2, 1'b1, 1'b0, 0, "R8 down");
      check("R8 consecutive neg", int'(spike[1]), 0);
    end
    // R6: large fall with channel off
    step(15, 0, 1'b0, 1'b0, 0, "R6 prep");
    step(0, 0, 1'b0, 1'b0, 0, "R6");
    check("R6 off stays high", int'(spike[1]), 1);

    // R1: asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 async prev", int'(prev), 0);
    check("R1 async spike", int'(spike), 2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule